// File: doc/BRIEF.md
# Debug Breakpoint Trigger Matcher

This block compares every memory access or instruction fetch against a small bank of breakpoint triggers. Each access brings an operation kind, the current privilege level, a debug-mode flag, an address, a data word and a width selector (32 or 64 bits). Each trigger has enables for operation kinds and privilege levels, a bit that picks address or data as the compared value, a chain bit, a compare mode, a compare value and a timing bit that is passed through on a hit.

Triggers are scanned from index 0 upward. A trigger with its chain bit set only qualifies the trigger after it, so a chain reports only when every member matches, and the report names the last member. The result is registered: one cycle after an access strobe the block shows a hit flag, the index of the reporting trigger and that trigger's timing bit. Trigger configuration is driven directly on ports by the surrounding register logic.

Top module: `trig_match_unit`

## Requirements
- R1: While `in_debug` is high during a strobed access, `hit` stays low in the following cycle.
- R2: Triggers are scanned in ascending index order, and the reported index is the lowest trigger that matches, is eligible and has its chain bit clear.
- R3: A trigger whose enable for the current operation is clear does not match; `acc_op` encodes 0 = execute, 1 = load, 2 = store, and 3 gates no trigger.
- R4: A trigger whose enable for the current privilege level is clear does not match; `acc_priv` encodes 0 = user, 1 = supervisor, 3 = machine, and 2 gates no trigger.
- R5: With `cfg_sel` set the access data is compared; with it clear the access address is compared.
- R6: With `xlen64` low the compared value is cut to its low 32 bits, the half-width used by the masked modes is 16, and the compare value is used at full width.
- R7: Mode 0 matches when the value equals the compare value; modes 6 and 7 never match.
- R8: Mode 1 (aligned power-of-two range) counts the trailing ones t of the compare value and matches when value and compare value agree on every bit above bit t.
- R9: Mode 2 matches when value >= compare value and mode 3 when value < compare value, both unsigned.
- R10: With h = half-width and mask = compare value >> h, mode 4 matches when (value & mask) == (compare & mask) and mode 5 when ((value >> h) & mask) == (compare & mask).
- R11: A matching trigger with its chain bit set does not report; the chain reports, under the index of its last member (chain bit clear), only when every member matches.
- R12: When a chain member is ineligible or fails to compare, every later member up to and including the next trigger with a clear chain bit is skipped, and scanning resumes after it.
- R13: `hit`, `hit_idx` and `hit_timing` are registered one cycle after `acc_valid`; `hit` is low after reset and in any cycle not preceded by a strobe, `hit_idx` and `hit_timing` are 0 whenever `hit` is low, and on a hit `hit_timing` is the reporting trigger's `cfg_timing` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_op | input | 2 | Operation kind |
| acc_priv | input | 2 | Privilege level |
| in_debug | input | 1 | Core is in debug mode |
| xlen64 | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| acc_addr | input | XW | Access address |
| acc_data | input | XW | Access data |
| cfg_exec | input | N | Per-trigger execute enable |
| cfg_load | input | N | Per-trigger load enable |
| cfg_store | input | N | Per-trigger store enable |
| cfg_m | input | N | Per-trigger machine-level enable |
| cfg_s | input | N | Per-trigger supervisor-level enable |
| cfg_u | input | N | Per-trigger user-level enable |
| cfg_sel | input | N | Per-trigger compare source, 1 = data |
| cfg_chain | input | N | Per-trigger chain bit |
| cfg_timing | input | N | Per-trigger timing bit |
| cfg_mode | input | 3*N | Per-trigger compare mode, trigger i in bits 3i+2:3i |
| cfg_cmp | input | XW*N | Per-trigger compare value, trigger i in bits XW*i+XW-1:XW*i |
| hit | output | 1 | A trigger reported |
| hit_idx | output | IW | Index of the reporting trigger |
| hit_timing | output | 1 | Timing bit of the reporting trigger |

## Verification
The assertions watch on every cycle that debug mode or a missing strobe leaves `hit` low, that index and timing are zero without a hit, that a reported trigger never has its chain bit set, and that the timing output follows the reported trigger's configuration. The compare modes, the width truncation, priority among several matches and the skipping of a broken chain depend on specific configurations and values, so only the bench's directed scenarios, with hand-worked expected indices, show those.

// File: rtl/trig_match_unit.sv
module trig_match_unit #(
  parameter int N  = 4,
  parameter int XW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [1:0]      acc_op,
  input  logic [1:0]      acc_priv,
  input  logic            in_debug,
  input  logic            xlen64,
  input  logic [XW-1:0]   acc_addr,
  input  logic [XW-1:0]   acc_data,
  input  logic [N-1:0]    cfg_exec,
  input  logic [N-1:0]    cfg_load,
  input  logic [N-1:0]    cfg_store,
  input  logic [N-1:0]    cfg_m,
  input  logic [N-1:0]    cfg_s,
  input  logic [N-1:0]    cfg_u,
  input  logic [N-1:0]    cfg_sel,
  input  logic [N-1:0]    cfg_chain,
  input  logic [N-1:0]    cfg_timing,
  input  logic [3*N-1:0]  cfg_mode,
  input  logic [XW*N-1:0] cfg_cmp,
  output logic            hit,
  output logic [IW-1:0]   hit_idx,
  output logic            hit_timing
);
  localparam int NW = XW / 2;
  localparam logic [2:0] MD_EQ = 3'd0, MD_NAPOT = 3'd1, MD_GE = 3'd2,
                         MD_LT = 3'd3, MD_MLO = 3'd4, MD_MHI = 3'd5;

  function automatic logic [XW-1:0] napot_mask(input logic [XW-1:0] c);
    logic run;
    logic [XW-1:0] m;
    run = 1'b1;
    for (int k = 0; k < XW; k++) begin
      m[k] = !run;
      run  = run & c[k];
    end
    return m;
  endfunction

  logic [N-1:0] elig, cmp_ok;

  wire op_gate_x = (acc_op == 2'd0);
  wire op_gate_l = (acc_op == 2'd1);
  wire op_gate_s = (acc_op == 2'd2);
  wire pv_gate_u = (acc_priv == 2'd0);
  wire pv_gate_s = (acc_priv == 2'd1);
  wire pv_gate_m = (acc_priv == 2'd3);

  for (genvar i = 0; i < N; i++) begin : g_trig
    logic [XW-1:0] cv, raw, val, hmask, nmask, vsh;
    logic [2:0]    md;
    assign cv   = cfg_cmp[XW*i +: XW];
    assign md   = cfg_mode[3*i +: 3];
    assign raw  = cfg_sel[i] ? acc_data : acc_addr;
    assign val  = xlen64 ? raw : {{NW{1'b0}}, raw[NW-1:0]};
    assign hmask = xlen64 ? (cv >> NW) : (cv >> (NW/2));
    assign vsh   = xlen64 ? (val >> NW) : (val >> (NW/2));
    assign nmask = napot_mask(cv);

    assign elig[i] = !((op_gate_x && !cfg_exec[i]) || (op_gate_l && !cfg_load[i]) ||
                       (op_gate_s && !cfg_store[i]) || (pv_gate_m && !cfg_m[i]) ||
                       (pv_gate_s && !cfg_s[i]) || (pv_gate_u && !cfg_u[i]));

    always_comb begin
      case (md)
        MD_EQ:    cmp_ok[i] = (val == cv);
        MD_NAPOT: cmp_ok[i] = ((val & nmask) == (cv & nmask));
        MD_GE:    cmp_ok[i] = (val >= cv);
        MD_LT:    cmp_ok[i] = (val < cv);
        MD_MLO:   cmp_ok[i] = ((val & hmask) == (cv & hmask));
        MD_MHI:   cmp_ok[i] = ((vsh & hmask) == (cv & hmask));
        default:  cmp_ok[i] = 1'b0;
      endcase
    end
  end

  logic          found;
  logic [IW-1:0] sel_idx;

  always_comb begin
    logic ok;
    ok      = 1'b1;
    found   = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!found) begin
        if (!ok) begin
          if (!cfg_chain[i]) ok = 1'b1;
        end else if (!elig[i] || !cmp_ok[i]) begin
          if (cfg_chain[i]) ok = 1'b0;
        end else if (!cfg_chain[i]) begin
          found   = 1'b1;
          sel_idx = i[IW-1:0];
        end
      end
    end
  end

  wire fire = acc_valid && !in_debug && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      hit_timing <= 1'b0;
    end else begin
      hit        <= fire;
      hit_idx    <= fire ? sel_idx : '0;
      hit_timing <= fire && cfg_timing[sel_idx];
    end
  end
endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          in_debug,
  input logic [N-1:0]  cfg_chain,
  input logic [N-1:0]  cfg_timing,
  input logic          hit,
  input logic [IW-1:0] hit_idx,
  input logic          hit_timing
);
  a_r1_debug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_debug) |=> !hit);

  a_r13_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);

  a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && !hit_timing));

  a_r11_no_chained_report: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !(($past(cfg_chain) >> hit_idx) & 1'b1));

  a_r13_timing_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_timing == (($past(cfg_timing) >> hit_idx) & 1'b1)));
endmodule

bind trig_match_unit trig_match_unit_chk #(.N(N)) u_chk (.*);

// File: tb/trig_match_unit_bench.sv
module trig_match_unit_bench;
  localparam int N = 4, XW = 64, IW = 2;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, in_debug = 0, xlen64 = 1;
  logic [1:0] acc_op = 0, acc_priv = 3;
  logic [XW-1:0] acc_addr = 0, acc_data = 0;
  logic [N-1:0] cfg_exec = 0, cfg_load = 0, cfg_store = 0, cfg_m = 0, cfg_s = 0, cfg_u = 0;
  logic [N-1:0] cfg_sel = 0, cfg_chain = 0, cfg_timing = 0;
  logic [3*N-1:0] cfg_mode = 0;
  logic [XW*N-1:0] cfg_cmp = 0;
  logic hit, hit_timing;
  logic [IW-1:0] hit_idx;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  trig_match_unit #(.N(N), .XW(XW)) u_trig_match_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    cfg_exec = 0; cfg_load = 0; cfg_store = 0; cfg_m = 0; cfg_s = 0; cfg_u = 0;
    cfg_sel = 0; cfg_chain = 0; cfg_timing = 0; cfg_mode = 0; cfg_cmp = 0;
    in_debug = 0; xlen64 = 1;
  endtask

  task automatic set_trig(input int i, input logic [2:0] md, input logic [XW-1:0] cv,
                          input logic sel, input logic ch);
    cfg_exec[i] = 1; cfg_load[i] = 1; cfg_store[i] = 1;
    cfg_m[i] = 1; cfg_s[i] = 1; cfg_u[i] = 1;
    cfg_sel[i] = sel; cfg_chain[i] = ch;
    cfg_mode[3*i +: 3] = md; cfg_cmp[XW*i +: XW] = cv;
  endtask

  task automatic access(input logic [1:0] op, input logic [1:0] pv,
                        input logic [XW-1:0] a, input logic [XW-1:0] d);
    @(negedge clk);
    acc_op = op; acc_priv = pv; acc_addr = a; acc_data = d; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic expect_res(input string tag, input logic h, input int idx, input logic tm);
    check({tag, " hit"}, 32'(hit), 32'(h));
    check({tag, " idx"}, 32'(hit_idx), 32'(idx));
    check({tag, " timing"}, 32'(hit_timing), 32'(tm));
  endtask

  task automatic t_reset();
    expect_res("R13 reset", 0, 0, 0);
  endtask

  task automatic t_basic();
    clear_all();
    set_trig(0, 3'd0, 64'h1234, 0, 0);
    access(0, 3, 64'h1234, 64'h0);  expect_res("R7 eq addr", 1, 0, 0);
    access(0, 3, 64'h1235, 64'h0);  expect_res("R7 eq miss", 0, 0, 0);
    @(negedge clk);                 expect_res("R13 no strobe", 0, 0, 0);
    cfg_sel[0] = 1;
    access(1, 3, 64'h0, 64'h1234);  expect_res("R5 data sel", 1, 0, 0);
    access(1, 3, 64'h1234, 64'h0);  expect_res("R5 addr ignored", 0, 0, 0);
    in_debug = 1;
    access(1, 3, 64'h0, 64'h1234);  expect_res("R1 debug", 0, 0, 0);
    in_debug = 0;
    cfg_mode[2:0] = 3'd6;
    access(1, 3, 64'h0, 64'h1234);  expect_res("R7 mode6", 0, 0, 0);
  endtask

  task automatic t_gating();
    clear_all();
    set_trig(0, 3'd0, 64'hA0, 0, 0);
    set_trig(1, 3'd0, 64'hA0, 0, 0);
    cfg_timing[1] = 1;
    access(2, 3, 64'hA0, 0);  expect_res("R2 lowest", 1, 0, 0);
    cfg_store[0] = 0;
    access(2, 3, 64'hA0, 0);  expect_res("R3 store off", 1, 1, 1);
    access(1, 3, 64'hA0, 0);  expect_res("R3 load on", 1, 0, 0);
    cfg_exec[0] = 0;
    access(0, 1, 64'hA0, 0);  expect_res("R3 exec off", 1, 1, 1);
    cfg_exec[0] = 1; cfg_store[0] = 1;
    cfg_s[0] = 0;
    access(0, 1, 64'hA0, 0);  expect_res("R4 s off", 1, 1, 1);
    access(0, 0, 64'hA0, 0);  expect_res("R4 u on", 1, 0, 0);
    cfg_u[0] = 0; cfg_u[1] = 0;
    access(0, 0, 64'hA0, 0);  expect_res("R4 u off", 0, 0, 0);
  endtask

  task automatic t_modes();
    clear_all();
    set_trig(0, 3'd1, 64'h1003, 0, 0);
    access(0, 3, 64'h1007, 0);  expect_res("R8 napot in", 1, 0, 0);
    access(0, 3, 64'h1008, 0);  expect_res("R8 napot out", 0, 0, 0);
    set_trig(0, 3'd2, 64'h100, 0, 0);
    access(0, 3, 64'h100, 0);   expect_res("R9 ge edge", 1, 0, 0);
    access(0, 3, 64'hFF, 0);    expect_res("R9 ge below", 0, 0, 0);
    set_trig(0, 3'd3, 64'h100, 0, 0);
    access(0, 3, 64'hFF, 0);    expect_res("R9 lt below", 1, 0, 0);
    access(0, 3, 64'h100, 0);   expect_res("R9 lt edge", 0, 0, 0);
    set_trig(0, 3'd4, 64'h0000_00FF_0000_0012, 0, 0);
    access(0, 3, 64'hABCD_0012, 0);  expect_res("R10 mlo hit", 1, 0, 0);
    access(0, 3, 64'hABCD_0013, 0);  expect_res("R10 mlo miss", 0, 0, 0);
    set_trig(0, 3'd5, 64'h0000_00FF_0000_0012, 0, 0);
    access(0, 3, 64'h0000_3412_0000_0000, 0);  expect_res("R10 mhi hit", 1, 0, 0);
    access(0, 3, 64'h0000_0012, 0);            expect_res("R10 mhi miss", 0, 0, 0);
  endtask

  task automatic t_narrow();
    clear_all();
    set_trig(0, 3'd0, 64'h8000_0000, 0, 0);
    access(0, 3, 64'hFFFF_FFFF_8000_0000, 0);  expect_res("R6 wide miss", 0, 0, 0);
    xlen64 = 0;
    access(0, 3, 64'hFFFF_FFFF_8000_0000, 0);  expect_res("R6 narrow hit", 1, 0, 0);
    set_trig(0, 3'd4, 64'h00FF_0034, 0, 0);
    access(0, 3, 64'h9934, 0);  expect_res("R6 narrow mlo", 1, 0, 0);
    access(0, 3, 64'h9935, 0);  expect_res("R6 narrow mlo miss", 0, 0, 0);
  endtask

  task automatic t_chain();
    clear_all();
    set_trig(0, 3'd0, 64'h40, 0, 1);
    set_trig(1, 3'd0, 64'h77, 1, 0);
    cfg_timing[1] = 1;
    access(1, 3, 64'h40, 64'h77);  expect_res("R11 chain all", 1, 1, 1);
    access(1, 3, 64'h40, 64'h78);  expect_res("R11 chain tail miss", 0, 0, 0);
    access(1, 3, 64'h41, 64'h77);  expect_res("R11 chain head miss", 0, 0, 0);
    set_trig(2, 3'd0, 64'h41, 0, 0);
    access(1, 3, 64'h41, 64'h77);  expect_res("R12 skip resume", 1, 2, 0);
    set_trig(1, 3'd0, 64'h41, 0, 0);
    cfg_timing[1] = 0;
    access(1, 3, 64'h41, 0);       expect_res("R12 skip terminator", 1, 2, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_gating();
        t_modes();
        t_narrow();
        t_chain();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule